// File: doc/BRIEF.md
# Frame-Synchronous Window Configuration Bank

This block keeps the configuration words of each overlay window of a display controller in two copies. Software writes and reads a staging copy over a plain register bus. The scan-out pipeline only ever sees a live copy. The live copy is refreshed from the staging copy only on a frame-boundary pulse, so a frame never starts with a half-written window setup.

Each window has a hold bit in a shared guard register. While a window's hold bit is set, frame pulses leave that window's live copy untouched. Software can therefore rewrite several words of a window across any number of frames, release the hold, and have the whole set take effect together on the next frame boundary. A one-shot commit request bit arms a transfer. With the `AUTO_LOAD` parameter at 1, every frame pulse refreshes the unheld windows. With it at 0, a refresh happens only while a commit request is armed. A per-window dirty flag shows which windows hold staged changes not yet made live.

Top module: `shadow_bank`

## Requirements
- R1: After reset, every live word, every dirty flag, the guard register and the commit request are 0, and every register reads as 0.
- R2: A write to a window word is returned by a read of that address from the next cycle on. The live outputs do not change in any cycle without a frame pulse.
- R3: On a clock edge with `vsync` high, each window that is not held and is allowed to transfer copies all of its staging words to its live words. With `AUTO_LOAD`=1, every unheld window is allowed.
- R4: The guard register is at address 0, with bit w as the hold bit of window w. A frame pulse leaves a held window's live words unchanged while the other windows still transfer.
- R5: After a window's hold bit is cleared, the frame pulse that follows applies all the values staged for it while it was held.
- R6: Clearing bit 0 (enable) of a window's control word drops `act_en` for that window only at the next transferring frame pulse.
- R7: The commit request is bit 0 of address 1. Writing 1 sets it and it reads back as 1. Writing 0 has no effect. It clears on the next frame pulse, unless a 1 is written in that same cycle.
- R8: With `AUTO_LOAD`=0, a frame pulse transfers an unheld window only while the commit request is armed.
- R9: `pending[w]` rises after any write to a window-w word and stays high through held frames. It falls at the edge where that window transfers, unless the window is written in that same cycle.
- R10: A window write in the same cycle as a transferring frame pulse is not part of that transfer. The live copy takes the value held before the write, and the new value goes live at the next transfer.
- R11: Window w word r sits at address 8*(w+1)+r, for r 0..5: control, base address, whole size, read offset, top-left position, bottom-right position. Any other address reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Frame-boundary pulse, one cycle high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, from the staging copy |
| act_cfg | output | NWIN*6*32 | Live words, window-major, word 0 lowest |
| act_en | output | NWIN | Live enable bit of each window |
| pending | output | NWIN | Per-window staged-but-not-live flag |

## Verification
On every cycle, the assertions check that the live words move only on a frame pulse. They also check that a held window keeps its live words through a pulse, that a transfer copies the staging words from the cycle before, that a transfer without a concurrent write clears the dirty flag, and that a consumed commit request disarms. Other behaviours need ordered multi-step stimulus and are shown only by the bench's scenarios. These are: staged values surviving several held frames and then appearing together after release, the enable bit lingering until the next transfer, writes colliding with a pulse, the address holes, and the difference between the two `AUTO_LOAD` variants.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int DW      = 32;
  localparam int AW      = 6;
  localparam int NREG    = 6;
  localparam int IDX_W   = 3;
  localparam logic [AW-1:0] GUARD_ADDR  = 6'd0;
  localparam logic [AW-1:0] COMMIT_ADDR = 6'd1;

  // Address of word r in window w.
  function automatic logic [AW-1:0] word_addr(input int w, input int r);
    return AW'(8 * (w + 1) + r);
  endfunction

  // True when addr selects a mapped word of window w.
  function automatic logic hits_window(input logic [AW-1:0] a, input int w);
    return (a[AW-1:IDX_W] == (AW-IDX_W)'(w + 1)) && (a[IDX_W-1:0] < IDX_W'(NREG));
  endfunction

  // Frame transfer condition for one window.
  function automatic logic may_load(input logic pulse, input logic held,
                                    input logic auto_mode, input logic armed);
    return pulse && !held && (auto_mode || armed);
  endfunction
endpackage

// File: rtl/shadow_win.sv
module shadow_win
  import shadow_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [IDX_W-1:0]     idx,
  input  logic [DW-1:0]        wdata,
  input  logic                 load,
  output logic [NREG*DW-1:0]   stage_q,
  output logic [NREG*DW-1:0]   live_q,
  output logic                 dirty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
      dirty   <= 1'b0;
    end else begin
      if (load) live_q <= stage_q;
      if (wr) begin
        stage_q[idx*DW +: DW] <= wdata;
        dirty <= 1'b1;
      end else if (load) begin
        dirty <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import shadow_bank_pkg::*;
#(
  parameter int NWIN      = 2,
  parameter bit AUTO_LOAD = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync,
  input  logic             guard_wr,
  input  logic             commit_wr,
  input  logic [DW-1:0]    wdata,
  output logic [NWIN-1:0]  hold,
  output logic             armed,
  output logic [NWIN-1:0]  load
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      armed <= 1'b0;
    end else begin
      if (guard_wr) hold <= wdata[NWIN-1:0];
      if (commit_wr && wdata[0]) armed <= 1'b1;
      else if (vsync)            armed <= 1'b0;
    end
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_load
    assign load[w] = may_load(vsync, hold[w], AUTO_LOAD, armed);
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int NWIN      = 2,
  parameter bit AUTO_LOAD = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vsync,
  input  logic                     wr_en,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic [NWIN*NREG*DW-1:0]  act_cfg,
  output logic [NWIN-1:0]          act_en,
  output logic [NWIN-1:0]          pending
);
  localparam int WBITS = NREG * DW;

  logic [NWIN-1:0]        hold;
  logic                   armed;
  logic [NWIN-1:0]        load;
  logic [NWIN-1:0]        win_sel;
  logic [NWIN-1:0]        win_wr;
  logic [NWIN*WBITS-1:0]  vis_all;
  logic                   guard_wr;
  logic                   commit_wr;

  assign guard_wr  = wr_en && (addr == GUARD_ADDR);
  assign commit_wr = wr_en && (addr == COMMIT_ADDR);

  bank_ctrl #(.NWIN(NWIN), .AUTO_LOAD(AUTO_LOAD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .vsync(vsync),
    .guard_wr(guard_wr), .commit_wr(commit_wr), .wdata(wdata),
    .hold(hold), .armed(armed), .load(load)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_sel[w] = hits_window(addr, w);
    assign win_wr[w]  = wr_en && win_sel[w];
    shadow_win u_win (
      .clk(clk), .rst_n(rst_n), .wr(win_wr[w]), .idx(addr[IDX_W-1:0]),
      .wdata(wdata), .load(load[w]),
      .stage_q(vis_all[w*WBITS +: WBITS]),
      .live_q(act_cfg[w*WBITS +: WBITS]),
      .dirty(pending[w])
    );
    assign act_en[w] = act_cfg[w*WBITS];
  end

  always_comb begin
    rdata = '0;
    if (addr == GUARD_ADDR)  rdata[NWIN-1:0] = hold;
    if (addr == COMMIT_ADDR) rdata[0] = armed;
    for (int w = 0; w < NWIN; w++) begin
      if (win_sel[w]) rdata = vis_all[(w*NREG + int'(addr[IDX_W-1:0]))*DW +: DW];
    end
  end
endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk
  import shadow_bank_pkg::*;
#(
  parameter int NWIN = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     vsync,
  input logic                     wr_en,
  input logic [AW-1:0]            addr,
  input logic [DW-1:0]            wdata,
  input logic [NWIN*NREG*DW-1:0]  act_cfg,
  input logic [NWIN-1:0]          pending,
  input logic                     armed,
  input logic [NWIN-1:0]          hold,
  input logic [NWIN-1:0]          load,
  input logic [NWIN-1:0]          win_wr,
  input logic [NWIN*NREG*DW-1:0]  vis_all
);
  localparam int WBITS = NREG * DW;

  // R2
  quiet_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(act_cfg));

  // R7
  commit_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && armed && !(wr_en && addr == COMMIT_ADDR && wdata[0])) |=> !armed);

  for (genvar w = 0; w < NWIN; w++) begin : g_chk
    // R4
    held_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && hold[w]) |=> $stable(act_cfg[w*WBITS +: WBITS]));

    // R3
    transfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load[w] |=> act_cfg[w*WBITS +: WBITS] == $past(vis_all[w*WBITS +: WBITS]));

    // R9
    dirty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load[w] && !win_wr[w]) |=> !pending[w]);
  end
endmodule

bind shadow_bank shadow_bank_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .act_cfg(act_cfg), .pending(pending), .armed(armed),
  .hold(hold), .load(load), .win_wr(win_wr), .vis_all(vis_all)
);

// File: tb/sim_shadow_bank.sv
`timescale 1ns/1ps
module sim_shadow_bank;
  localparam int NW = 2;
  localparam int NR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [NW*NR*32-1:0] cfg0, cfg1;
  logic [NW-1:0] en0, en1, pend0, pend1;

  always #4 clk = ~clk;

  shadow_bank #(.NWIN(NW), .AUTO_LOAD(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata0), .act_cfg(cfg0), .act_en(en0), .pending(pend0));
  shadow_bank #(.NWIN(NW), .AUTO_LOAD(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata1), .act_cfg(cfg1), .act_en(en1), .pending(pend1));

  // Reference state: index 0 models u0 (auto), index 1 models u1 (commit-gated).
  logic [31:0] m_vis [2][NW][NR];
  logic [31:0] m_act [2][NW][NR];
  logic [NW-1:0] m_hold [2];
  logic m_arm [2];
  logic [NW-1:0] m_pend [2];
  int vectors = 0, errors = 0;
  bit done = 0;

  function automatic void model_reset();
    for (int i = 0; i < 2; i++) begin
      m_hold[i] = '0; m_arm[i] = 0; m_pend[i] = '0;
      for (int w = 0; w < NW; w++)
        for (int r = 0; r < NR; r++) begin m_vis[i][w][r] = '0; m_act[i][w][r] = '0; end
    end
  endfunction

  function automatic void model_edge(int i, bit vs, bit we, logic [5:0] a, logic [31:0] d);
    bit go [NW];
    for (int w = 0; w < NW; w++)
      go[w] = vs && !m_hold[i][w] && (i == 0 || m_arm[i]);
    for (int w = 0; w < NW; w++)
      if (go[w]) begin
        for (int r = 0; r < NR; r++) m_act[i][w][r] = m_vis[i][w][r];
        m_pend[i][w] = 0;
      end
    if (we && a == 0) m_hold[i] = d[NW-1:0];
    if (we && a == 1 && d[0]) m_arm[i] = 1;
    else if (vs) m_arm[i] = 0;
    if (we && a >= 8 && int'(a) < 8 * (NW + 1) && a[2:0] < NR) begin
      m_vis[i][int'(a[5:3]) - 1][a[2:0]] = d;
      m_pend[i][int'(a[5:3]) - 1] = 1;
    end
  endfunction

  function automatic logic [31:0] model_read(int i, logic [5:0] a);
    if (a == 0) return 32'(m_hold[i]);
    if (a == 1) return 32'(m_arm[i]);
    if (a >= 8 && int'(a) < 8 * (NW + 1) && a[2:0] < NR) return m_vis[i][int'(a[5:3]) - 1][a[2:0]];
    return '0;
  endfunction

  function automatic logic [NW*NR*32-1:0] model_cfg(int i);
    logic [NW*NR*32-1:0] v;
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++) v[(w*NR + r)*32 +: 32] = m_act[i][w][r];
    return v;
  endfunction

  function automatic logic [NW-1:0] model_en(int i);
    logic [NW-1:0] e;
    for (int w = 0; w < NW; w++) e[w] = m_act[i][w][0][0];
    return e;
  endfunction

  task automatic compare(input string tag);
    logic [NW*NR*32-1:0] c;
    logic [31:0] rd;
    logic [NW-1:0] e, p;
    for (int i = 0; i < 2; i++) begin
      c  = (i == 0) ? cfg0 : cfg1;
      rd = (i == 0) ? rdata0 : rdata1;
      e  = (i == 0) ? en0 : en1;
      p  = (i == 0) ? pend0 : pend1;
      vectors++;
      if (c !== model_cfg(i)) begin
        errors++; $display("FAIL %s u%0d act_cfg actual %h expected %h", tag, i, c, model_cfg(i));
      end
      if (e !== model_en(i)) begin
        errors++; $display("FAIL %s u%0d act_en actual %b expected %b", tag, i, e, model_en(i));
      end
      if (p !== m_pend[i]) begin
        errors++; $display("FAIL %s u%0d pending actual %b expected %b", tag, i, p, m_pend[i]);
      end
      if (rd !== model_read(i, addr)) begin
        errors++; $display("FAIL %s u%0d rdata@%0d actual %h expected %h", tag, i, addr, rd, model_read(i, addr));
      end
    end
  endtask

  task automatic step(input bit vs, input bit we, input logic [5:0] a,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    vsync = vs; wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    model_edge(0, vs, we, a, d);
    model_edge(1, vs, we, a, d);
    #1;
    compare(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [5:0] ra;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 compare("R1");
    step(0, 0, 6'd0, 0, "R1");

    // R2: staging write is readable, live copy untouched
    step(0, 1, 6'd9, 32'h1000_0000, "R2");
    step(0, 0, 6'd9, 0, "R2");
    // R3 / R8: pulse loads u0, u1 waits for a commit request
    step(1, 0, 6'd9, 0, "R3");
    step(0, 0, 6'd9, 0, "R8");
    // R4: hold window 0, stage changes in both, pulse loads only window 1
    step(0, 1, 6'd0, 32'h1, "R4");
    step(0, 1, 6'd10, 32'h0438_0780, "R4");
    step(0, 1, 6'd17, 32'h2000_0000, "R4");
    step(1, 0, 6'd10, 0, "R4");
    step(1, 0, 6'd0, 0, "R9");
    // R5: release the hold, next pulse applies staged window 0 words
    step(0, 1, 6'd0, 32'h0, "R5");
    step(1, 0, 6'd10, 0, "R5");
    // R6: enable set, then cleared; act_en lingers until a pulse
    step(0, 1, 6'd8, 32'h0000_0003, "R6");
    step(1, 0, 6'd8, 0, "R6");
    step(0, 1, 6'd8, 32'h0000_0002, "R6");
    step(0, 0, 6'd8, 0, "R6");
    step(0, 0, 6'd8, 0, "R6");
    step(1, 0, 6'd8, 0, "R6");
    // R7 / R8: commit request, write-0 ignored, consumed by pulse
    step(0, 1, 6'd1, 32'h0, "R7");
    step(0, 1, 6'd1, 32'h1, "R7");
    step(0, 0, 6'd1, 0, "R7");
    step(1, 0, 6'd1, 0, "R8");
    step(0, 1, 6'd1, 32'h1, "R7");
    step(1, 1, 6'd1, 32'h1, "R7");
    step(1, 0, 6'd1, 0, "R7");
    // R10: write colliding with a pulse goes live one transfer later
    step(0, 1, 6'd1, 32'h1, "R10");
    step(0, 1, 6'd19, 32'h0011_0022, "R10");
    step(1, 1, 6'd19, 32'h0033_0044, "R10");
    step(0, 1, 6'd1, 32'h1, "R10");
    step(1, 0, 6'd19, 0, "R10");
    // R11: address holes
    step(0, 1, 6'd14, 32'hDEAD_BEEF, "R11");
    step(0, 1, 6'd62, 32'hDEAD_BEEF, "R11");
    step(0, 0, 6'd14, 0, "R11");
    step(0, 0, 6'd2, 0, "R11");
    step(1, 0, 6'd62, 0, "R11");
    step(0, 0, 6'd21, 0, "R11");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      int pick = $urandom_range(0, 9);
      if (pick == 0) ra = 6'd0;
      else if (pick == 1) ra = 6'd1;
      else if (pick == 2) ra = 6'($urandom_range(0, 63));
      else ra = 6'(8 * $urandom_range(1, NW) + $urandom_range(0, NR - 1));
      step($urandom_range(0, 7) == 0, $urandom_range(0, 2) != 0, ra, $urandom, "R3");
    end
    finish_run();
  end
endmodule